// File: doc/BRIEF.md
# Tag-Renaming Reservation Station Array

This block is the out-of-order scheduling core of a small floating-point style datapath. Instructions arrive in program order on an issue port. Each one claims a free station in the class its operation needs: adder class or multiplier class. Each source operand is copied into the station either as a value or as the tag of the station that will produce it. The destination register is then marked as owned by the new station's tag. Because registers are renamed to station tags, a later write to a register never waits for earlier readers or writers of that register.

Stations watch a single shared result bus and capture any missing operand whose tag matches the broadcast. A station whose operands are both values is handed to its functional unit. Each unit is modelled as a non-pipelined fixed-latency engine that holds its result until it wins the bus. The register file is internal and comes out of reset with register r holding r+1. A read port exposes each register's value and its pending tag.

Top module: `rs_array`

## Requirements
- R1: After reset, every register r reads value r+1 with tag 0, no broadcast is active, and an issue of either class is accepted.
- R2: Stations 1..N_ADD serve opcodes 00 (add) and 01 (sub, first minus second). Stations N_ADD+1..N_ADD+N_MUL serve opcodes 10 (low half of the product) and 11 (high half of the product). `issue_ready` is low while every station of the requested class is busy, and the instruction stays on the port until it is accepted.
- R3: In the cycle after an accepted issue, the destination register reports a nonzero tag naming the new station. The tag stays nonzero until that station broadcasts.
- R4: A source whose register has a pending tag waits for that tag. Execution starts only once both sources hold values. The final register contents equal in-order execution of the accepted instructions.
- R5: A broadcast carries a nonzero tag of a busy station together with its result. Every station and register waiting on that tag takes the value, and the broadcasting station becomes free.
- R6: When several stations of one class are ready in the same cycle, the lowest-numbered one is handed to the unit first.
- R7: When both units hold a finished result, the multiplier unit owns the bus and the adder unit waits.
- R8: A register takes a broadcast value only if its tag still equals the broadcast tag, so a later renaming of the register keeps ownership.
- R9: An instruction issued in the same cycle as the broadcast of one of its sources takes that value directly and does not wait on the tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Instruction present on the issue port |
| issue_op | input | 2 | Opcode: 00 add, 01 sub, 10 product low, 11 product high |
| issue_rd | input | RW | Destination register |
| issue_rs1 | input | RW | First source register |
| issue_rs2 | input | RW | Second source register |
| issue_ready | output | 1 | A station of the requested class is free |
| rd_addr | input | RW | Register read select |
| rd_value | output | DW | Value of the selected register |
| rd_tag | output | TW | Pending producer tag of the selected register, 0 if none |
| cdb_valid | output | 1 | Result broadcast active |
| cdb_tag | output | TW | Tag of the broadcasting station |
| cdb_value | output | DW | Broadcast result |

## Verification
The assertions check on every cycle that a broadcast names a legal, busy station, that the multiplier wins any bus collision, that an accepted issue renames its destination to the new tag, and that a full class refuses issue. Whether renaming, tag matching and same-cycle forwarding produce correct register contents can only be shown by the bench's scenarios. These compare the registers against an in-order model after random programs, a write-after-write race and issues placed at swept distances from a broadcast. The lowest-index dispatch order is also shown only by a directed scenario that releases three adder stations at once.

// File: rtl/rs_array.sv
module rs_array #(
  parameter int N_ADD   = 3,
  parameter int N_MUL   = 2,
  parameter int NREG    = 8,
  parameter int DW      = 16,
  parameter int ADD_LAT = 2,
  parameter int MUL_LAT = 4,
  localparam int NRS = N_ADD + N_MUL,
  localparam int TW  = $clog2(NRS + 1),
  localparam int RW  = $clog2(NREG),
  localparam int CW  = $clog2((ADD_LAT > MUL_LAT ? ADD_LAT : MUL_LAT) + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue_valid,
  input  logic [1:0]    issue_op,
  input  logic [RW-1:0] issue_rd,
  input  logic [RW-1:0] issue_rs1,
  input  logic [RW-1:0] issue_rs2,
  output logic          issue_ready,
  input  logic [RW-1:0] rd_addr,
  output logic [DW-1:0] rd_value,
  output logic [TW-1:0] rd_tag,
  output logic          cdb_valid,
  output logic [TW-1:0] cdb_tag,
  output logic [DW-1:0] cdb_value
);

  logic [NREG-1:0][DW-1:0] reg_val;
  logic [NREG-1:0][TW-1:0] reg_tag;

  logic [NRS-1:0]          st_busy, st_disp;
  logic [NRS-1:0][1:0]     st_op;
  logic [NRS-1:0][DW-1:0]  st_vj, st_vk;
  logic [NRS-1:0][TW-1:0]  st_qj, st_qk;

  logic [1:0]              u_busy, u_done;
  logic [1:0][CW-1:0]      u_cnt;
  logic [1:0][DW-1:0]      u_res;
  logic [1:0][TW-1:0]      u_tag;

  logic [1:0]              d_ok;
  logic [1:0][TW-1:0]      d_idx;
  logic [1:0][DW-1:0]      d_res;

  logic                    have_free, issue_fire;
  logic [TW-1:0]           new_idx, new_tag;
  logic [DW-1:0]           s1_val, s2_val;
  logic [TW-1:0]           s1_tag, s2_tag;

  assign rd_value  = reg_val[rd_addr];
  assign rd_tag    = reg_tag[rd_addr];

  assign cdb_valid = |u_done;
  assign cdb_tag   = u_done[1] ? u_tag[1] : u_tag[0];
  assign cdb_value = u_done[1] ? u_res[1] : u_res[0];

  always_comb begin
    have_free = 1'b0;
    new_idx   = '0;
    for (int i = NRS - 1; i >= 0; i--) begin
      if (!st_busy[i] && ((i >= N_ADD) == issue_op[1])) begin
        have_free = 1'b1;
        new_idx   = TW'(i);
      end
    end
  end

  assign issue_ready = have_free;
  assign issue_fire  = issue_valid && have_free;
  assign new_tag     = new_idx + 1'b1;

  always_comb begin
    s1_val = reg_val[issue_rs1];
    s1_tag = reg_tag[issue_rs1];
    if (s1_tag != '0 && cdb_valid && s1_tag == cdb_tag) begin
      s1_val = cdb_value;
      s1_tag = '0;
    end
    s2_val = reg_val[issue_rs2];
    s2_tag = reg_tag[issue_rs2];
    if (s2_tag != '0 && cdb_valid && s2_tag == cdb_tag) begin
      s2_val = cdb_value;
      s2_tag = '0;
    end
  end

  always_comb begin
    logic [2*DW-1:0] prod;
    logic [DW-1:0]   a, b;
    for (int u = 0; u < 2; u++) begin
      d_ok[u]  = 1'b0;
      d_idx[u] = '0;
      for (int i = NRS - 1; i >= 0; i--) begin
        if (((i >= N_ADD) == (u == 1)) && st_busy[i] && !st_disp[i] &&
            st_qj[i] == '0 && st_qk[i] == '0 && !u_busy[u]) begin
          d_ok[u]  = 1'b1;
          d_idx[u] = TW'(i);
        end
      end
    end
    a        = st_vj[d_idx[0]];
    b        = st_vk[d_idx[0]];
    d_res[0] = st_op[d_idx[0]][0] ? a - b : a + b;
    a        = st_vj[d_idx[1]];
    b        = st_vk[d_idx[1]];
    prod     = {{DW{1'b0}}, a} * {{DW{1'b0}}, b};
    d_res[1] = st_op[d_idx[1]][0] ? prod[2*DW-1:DW] : prod[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) begin
        reg_val[r] <= DW'(r + 1);
        reg_tag[r] <= '0;
      end
    end else begin
      for (int r = 0; r < NREG; r++) begin
        if (cdb_valid && reg_tag[r] != '0 && reg_tag[r] == cdb_tag) begin
          reg_val[r] <= cdb_value;
          reg_tag[r] <= '0;
        end
        if (issue_fire && issue_rd == RW'(r))
          reg_tag[r] <= new_tag;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_busy <= '0;
      st_disp <= '0;
      st_op   <= '0;
      st_vj   <= '0;
      st_vk   <= '0;
      st_qj   <= '0;
      st_qk   <= '0;
    end else begin
      for (int i = 0; i < NRS; i++) begin
        if (cdb_valid && st_busy[i] && st_qj[i] != '0 && st_qj[i] == cdb_tag) begin
          st_vj[i] <= cdb_value;
          st_qj[i] <= '0;
        end
        if (cdb_valid && st_busy[i] && st_qk[i] != '0 && st_qk[i] == cdb_tag) begin
          st_vk[i] <= cdb_value;
          st_qk[i] <= '0;
        end
        if (d_ok[(i >= N_ADD) ? 1 : 0] && d_idx[(i >= N_ADD) ? 1 : 0] == TW'(i))
          st_disp[i] <= 1'b1;
        if (cdb_valid && cdb_tag == TW'(i + 1)) begin
          st_busy[i] <= 1'b0;
          st_disp[i] <= 1'b0;
        end
        if (issue_fire && new_idx == TW'(i)) begin
          st_busy[i] <= 1'b1;
          st_disp[i] <= 1'b0;
          st_op[i]   <= issue_op;
          st_vj[i]   <= s1_val;
          st_qj[i]   <= s1_tag;
          st_vk[i]   <= s2_val;
          st_qk[i]   <= s2_tag;
        end
      end
    end
  end

  for (genvar u = 0; u < 2; u++) begin : g_unit
    localparam int LAT = (u == 0) ? ADD_LAT : MUL_LAT;
    logic won;
    assign won = (u == 1) ? u_done[1] : (u_done[0] && !u_done[1]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        u_busy[u] <= 1'b0;
        u_done[u] <= 1'b0;
        u_cnt[u]  <= '0;
        u_res[u]  <= '0;
        u_tag[u]  <= '0;
      end else begin
        if (u_busy[u] && !u_done[u]) begin
          if (u_cnt[u] == '0) u_done[u] <= 1'b1;
          else                u_cnt[u]  <= u_cnt[u] - 1'b1;
        end
        if (won) begin
          u_busy[u] <= 1'b0;
          u_done[u] <= 1'b0;
        end
        if (d_ok[u]) begin
          u_busy[u] <= 1'b1;
          u_cnt[u]  <= CW'(LAT - 1);
          u_res[u]  <= d_res[u];
          u_tag[u]  <= d_idx[u] + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/rs_array_chk.sv
module rs_array_chk #(
  parameter int N_ADD = 3,
  parameter int NRS   = 5,
  parameter int NREG  = 8,
  parameter int TW    = 3,
  parameter int RW    = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    issue_valid,
  input logic [1:0]              issue_op,
  input logic [RW-1:0]           issue_rd,
  input logic                    issue_ready,
  input logic                    issue_fire,
  input logic [TW-1:0]           new_tag,
  input logic                    cdb_valid,
  input logic [TW-1:0]           cdb_tag,
  input logic [NRS-1:0]          st_busy,
  input logic [1:0]              u_done,
  input logic [NREG-1:0][TW-1:0] reg_tag
);

  AST_CDB_TAG_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    cdb_valid |-> (cdb_tag != '0 && int'(cdb_tag) <= NRS)); // R5

  AST_CDB_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (cdb_valid && cdb_tag != '0 && int'(cdb_tag) <= NRS) |-> st_busy[cdb_tag - 1'b1]); // R5

  AST_BUS_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (u_done == 2'b11) |-> (int'(cdb_tag) > N_ADD)); // R7

  AST_RENAME_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    issue_fire |=> (reg_tag[$past(issue_rd)] == $past(new_tag) && $past(new_tag) != '0)); // R3

  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    ((&st_busy[N_ADD-1:0]) && issue_valid && !issue_op[1]) |-> !issue_ready); // R2

endmodule

bind rs_array rs_array_chk #(.N_ADD(N_ADD), .NRS(NRS), .NREG(NREG), .TW(TW), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_op(issue_op),
  .issue_rd(issue_rd), .issue_ready(issue_ready), .issue_fire(issue_fire),
  .new_tag(new_tag), .cdb_valid(cdb_valid), .cdb_tag(cdb_tag),
  .st_busy(st_busy), .u_done(u_done), .reg_tag(reg_tag)
);

// File: tb/rs_array_tb.sv
module rs_array_tb;
  localparam int NREG = 8;
  localparam int DW   = 16;
  localparam int TW   = 3;
  localparam int RW   = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          issue_valid = 1'b0;
  logic [1:0]    issue_op = '0;
  logic [RW-1:0] issue_rd = '0, issue_rs1 = '0, issue_rs2 = '0;
  logic          issue_ready;
  logic [RW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_value;
  logic [TW-1:0] rd_tag;
  logic          cdb_valid;
  logic [TW-1:0] cdb_tag;
  logic [DW-1:0] cdb_value;

  int checks = 0, fails = 0;
  logic [DW-1:0] m [NREG];
  logic          log_en = 1'b0;
  int            log_n = 0;
  logic [TW-1:0] log_tag [8];

  always #4 clk = ~clk;

  rs_array u_dut (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_op(issue_op),
    .issue_rd(issue_rd), .issue_rs1(issue_rs1), .issue_rs2(issue_rs2),
    .issue_ready(issue_ready), .rd_addr(rd_addr), .rd_value(rd_value),
    .rd_tag(rd_tag), .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value)
  );

  always @(negedge clk) begin
    if (log_en && cdb_valid && cdb_tag >= 1 && cdb_tag <= 3 && log_n < 8) begin
      log_tag[log_n] = cdb_tag;
      log_n++;
    end
  end

  function automatic logic [DW-1:0] calc(input logic [1:0] op, input logic [DW-1:0] a, b);
    logic [2*DW-1:0] p;
    p = {{DW{1'b0}}, a} * {{DW{1'b0}}, b};
    case (op)
      2'b00:   return a + b;
      2'b01:   return a - b;
      2'b10:   return p[DW-1:0];
      default: return p[2*DW-1:DW];
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int r = 0; r < NREG; r++) m[r] = DW'(r + 1);
  endtask

  task automatic issue(input logic [1:0] op, input int rd, input int rs1, input int rs2);
    @(negedge clk);
    issue_valid = 1'b1; issue_op = op;
    issue_rd = RW'(rd); issue_rs1 = RW'(rs1); issue_rs2 = RW'(rs2);
    #1;
    while (!issue_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    m[rd] = calc(op, m[rs1], m[rs2]);
    @(negedge clk);
    issue_valid = 1'b0;
    rd_addr = RW'(rd);
    #1;
    chk(rd_tag != '0, "R3 destination renamed", rd_tag, 1);
  endtask

  task automatic check_regs(input string req);
    @(negedge clk);
    for (int r = 0; r < NREG; r++) begin
      rd_addr = RW'(r);
      #1;
      chk(rd_value == m[r] && rd_tag == '0, req, rd_value, m[r]);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));

    do_reset();
    // R1 reset state
    @(negedge clk);
    chk(!cdb_valid, "R1 no broadcast after reset", cdb_valid, 0);
    issue_valid = 1'b1; issue_op = 2'b00; #1;
    chk(issue_ready, "R1 adder issue accepted", issue_ready, 1);
    issue_op = 2'b10; #1;
    chk(issue_ready, "R1 multiplier issue accepted", issue_ready, 1);
    issue_valid = 1'b0;
    check_regs("R1 reset register contents");

    // R2 and R6: three adders all waiting on one product
    log_n = 0; log_en = 1'b1;
    issue(2'b10, 1, 1, 1);
    issue(2'b00, 4, 1, 1);
    issue(2'b00, 5, 1, 0);
    issue(2'b01, 6, 1, 7);
    @(negedge clk);
    issue_valid = 1'b1; issue_op = 2'b00; issue_rd = 0; issue_rs1 = 0; issue_rs2 = 0; #1;
    chk(!issue_ready, "R2 adder class full stalls issue", issue_ready, 0);
    issue_op = 2'b11; #1;
    chk(issue_ready, "R2 multiplier class still free", issue_ready, 1);
    issue_valid = 1'b0;
    repeat (40) @(posedge clk);
    log_en = 1'b0;
    chk(log_n == 3, "R6 adder broadcast count", log_n, 3);
    chk(log_tag[0] == 1 && log_tag[1] == 2 && log_tag[2] == 3,
        "R6 lowest station first", {log_tag[0], log_tag[1], log_tag[2]}, 9'o123);
    check_regs("R4 R5 dependent results");

    // R8: slow product then fast add on the same register
    issue(2'b10, 2, 3, 3);
    issue(2'b00, 2, 0, 0);
    issue(2'b11, 3, 7, 7);
    repeat (30) @(posedge clk);
    rd_addr = 2; #1;
    chk(rd_value == m[2], "R8 later rename keeps ownership", rd_value, m[2]);
    check_regs("R8 register file after race");

    // R9: consumer issued at swept distance from producer broadcast
    for (int k = 0; k < 6; k++) begin
      issue(2'b00, 1, 0, 2);
      repeat (k) @(negedge clk);
      issue(2'b00, 2, 1, 0);
      issue(2'b01, 5, 1, 2);
      repeat (20) @(posedge clk);
      check_regs("R9 same-cycle forward at issue");
    end

    // R4 R7: random programs against in-order model
    for (int s = 0; s < 30; s++) begin
      for (int n = 0; n < 12; n++) begin
        int gap;
        issue(2'($urandom_range(0, 3)), int'($urandom_range(0, NREG - 1)),
              int'($urandom_range(0, NREG - 1)), int'($urandom_range(0, NREG - 1)));
        gap = int'($urandom_range(0, 2));
        repeat (gap) @(negedge clk);
      end
      repeat (60) @(posedge clk);
      check_regs("R4 R7 random program");
      if (s % 10 == 9) begin
        do_reset();
        check_regs("R1 reset between programs");
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule